// File: doc/BRIEF.md
# Table-Driven Video Pattern Generator

This block produces a complete video signal from a lookup table. A free-running address counter steps through a pattern memory once per clock. Each stored byte supplies the colour bits, both sync levels and a frame-end marker for one slice of the picture. All timing comes from the table contents and none from comparators. That covers pulse widths, porches, line length and frame length. A host fills the table through a simple write port while the scan is held in load mode. Releasing load starts the scan from word 0.

Each word covers eight pixel periods, so the counter runs at one eighth of the pixel clock. For an 800x600 frame on a 1056 x 628 raster, a line takes 132 words and a frame takes 82896 words. That is 100 colour slots across the visible width. A full frame needs `ADDR_W` = 17. The default is a shorter table so that elaboration stays small; `ADDR_W` is raised at integration.

Memory reads are registered, so every output follows the counter by one clock. The frame-end marker is taken from the registered word. After a word with the marker set, one more word (the next address) is emitted before word 0 returns. The stored pattern must allow for this extra slot.

Top module: `vpg_top`

## Requirements
- R1: While rst_ni is low, all outputs read 0 and the counter is 0. After release with load_i low, the first word emitted is word 0.
- R2: With load_i low, the counter advances by one per clock. The outputs present the word at the previous clock's counter value, one clock after that value was applied.
- R3: Output fields come from the stored byte as follows: bit 7 vsync_o, bit 6 hsync_o, bit 5 pend_o, bit 4 blue_o, bits 3:2 green_o, bits 1:0 red_o.
- R4: Suppose word A is emitted with bit 5 set. On the next clock word A+1 is emitted, and on the clock after that word 0 is emitted again.
- R5: If no bit 5 is set, the counter wraps from 2^ADDR_W-1 to 0, and scanning continues with word 0.
- R6: While load_i is high, all outputs read 0 and the counter is held at 0. The first word emitted after load_i falls is word 0.
- R7: A write with we_i high stores wdata_i at waddr_i only when load_i is also high. A write while load_i is low leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock (pixel clock / 8) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load mode: hold scan at 0, blank outputs, enable writes |
| we_i | input | 1 | Table write strobe |
| waddr_i | input | ADDR_W | Table write address |
| wdata_i | input | 8 | Table write data |
| red_o | output | 2 | Red level |
| green_o | output | 2 | Green level |
| blue_o | output | 1 | Blue level |
| hsync_o | output | 1 | Horizontal sync level |
| vsync_o | output | 1 | Vertical sync level |
| pend_o | output | 1 | Frame-end marker of the current word |

## Verification
The hardest situation to reach from the ports is the natural counter wrap. It needs a table with no frame-end marker anywhere and a full pass of 2^ADDR_W clocks. The bench loads a table with bit 5 cleared in every word and scans past the wrap point, comparing every slot. The one-slot-late restart is reached with a directed marker at a chosen address. An attempted write during scanning is made before the scan returns to the targeted word, so the ignored write is observed at the outputs.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  localparam int unsigned WORD_W = 8;

  typedef struct packed {
    logic       vs;
    logic       hs;
    logic       pend;
    logic       blu;
    logic [1:0] grn;
    logic [1:0] red;
  } vpg_word_t;
endpackage

// File: rtl/vpg_addr_ctr.sv
module vpg_addr_ctr #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              pend_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= '0;
    else if (pend_i)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign addr_o = cnt_q;

  p_hold_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !pend_i) |=> (cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));
  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && pend_i) |=> (cnt_q == '0));
endmodule

// File: rtl/vpg_pattern_mem.sv
module vpg_pattern_mem
  import vpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   waddr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]   raddr_i,
  output vpg_word_t           word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  vpg_word_t         word_q;

  // writes only in load mode; scan never sees a torn update
  always_ff @(posedge clk_i) begin
    if (load_i && we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read doubles as the output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= '0;
    else             word_q <= vpg_word_t'(mem_q[raddr_i]);
  end

  assign word_o = word_q;

  p_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_q == '0));
endmodule

// File: rtl/vpg_top.sv
module vpg_top
  import vpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  output logic [1:0]        red_o,
  output logic [1:0]        green_o,
  output logic              blue_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              pend_o
);
  logic [ADDR_W-1:0] addr;
  vpg_word_t         word;

  vpg_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .pend_i (word.pend),
    .addr_o (addr)
  );

  vpg_pattern_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .raddr_i (addr),
    .word_o  (word)
  );

  assign red_o   = word.red;
  assign green_o = word.grn;
  assign blue_o  = word.blu;
  assign hsync_o = word.hs;
  assign vsync_o = word.vs;
  assign pend_o  = word.pend;

  // frame end is followed by exactly one more slot, then word 0 is fetched
  p_addr_after_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !load_i) |=> (addr == '0));
  p_addr_in_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !pend_o) |=> (addr == '0) && !pend_o);
endmodule

// File: tb/sim_vpg_top.sv
module sim_vpg_top;
  localparam int unsigned AW     = 11;
  localparam int unsigned DEPTH  = 1 << AW;
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [7:0]    wdata = '0;
  logic [1:0]    red, green;
  logic          blue, hsync, vsync, pend;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  logic [7:0]    m_mem [DEPTH];
  logic [AW-1:0] m_cnt = '0;
  logic [7:0]    m_word = '0;

  always #(CLK_PER/2) clk = ~clk;

  vpg_top #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata),
    .red_o(red), .green_o(green), .blue_o(blue),
    .hsync_o(hsync), .vsync_o(vsync), .pend_o(pend)
  );

  function automatic logic [7:0] dut_word();
    return {vsync, hsync, pend, blue, green, red};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model follows the requirements, then compare away from the edge
  task automatic step(input string req);
    logic [7:0] nw;
    @(posedge clk);
    if (load) begin
      if (we) m_mem[waddr] = wdata;
      nw    = 8'h00;
      m_cnt = '0;
    end else begin
      nw    = m_mem[m_cnt];
      m_cnt = m_word[5] ? '0 : m_cnt + 1'b1;
    end
    m_word = nw;
    @(negedge clk);
    chk(req, dut_word(), m_word);
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [7:0] d);
    we = 1'b1; waddr = a; wdata = d;
    step("R6");
    we = 1'b0;
  endtask

  task automatic fill(input int end_at);
    load = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] d;
      d = 8'($urandom());
      d[5] = (i == end_at);
      write_word(AW'(i), d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", dut_word(), 8'h00);
    load = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", dut_word(), 8'h00);

    // R3: directed field layout at word 0, frame end at 37
    fill(37);
    write_word('0, 8'b1010_0110);
    load = 1'b0;
    step("R1");
    chk("R3 red",   {6'b0, red},   8'h02);
    chk("R3 green", {6'b0, green}, 8'h01);
    chk("R3 blue",  {7'b0, blue},  8'h00);
    chk("R3 pend",  {7'b0, pend},  8'h01);
    chk("R3 hsync", {7'b0, hsync}, 8'h00);
    chk("R3 vsync", {7'b0, vsync}, 8'h01);
    // word 0 carries an end mark: next is word 1, then word 0
    step("R4");
    chk("R4", dut_word(), m_mem[1]);
    step("R4");
    chk("R4", dut_word(), 8'b1010_0110);

    // clear end at 0 via reload, then scan past end mark at 37 (R2, R4)
    load = 1'b1;
    write_word('0, 8'h5a);
    load = 1'b0;
    for (int i = 0; i < 120; i++) begin
      step("R2");
      if (i == 10) begin
        // R7: write attempt while scanning must not reach the table
        we = 1'b1; waddr = '0; wdata = 8'hff;
      end else begin
        we = 1'b0;
      end
    end
    chk("R7", m_mem[0], 8'h5a);

    // R6: load mid-scan blanks and restarts at word 0
    repeat (5) step("R2");
    load = 1'b1;
    step("R6");
    step("R6");
    chk("R6", dut_word(), 8'h00);
    load = 1'b0;
    step("R6");
    chk("R6", dut_word(), 8'h5a);

    // R5: no end mark anywhere, scan across the natural wrap
    fill(-1);
    load = 1'b0;
    for (int i = 0; i < DEPTH + 40; i++) step("R5");

    // random load toggling with random end positions
    for (int k = 0; k < 3; k++) begin
      fill(int'($urandom_range(5, 300)));
      load = 1'b0;
      for (int i = 0; i < 400; i++) begin
        load = ($urandom_range(0, 99) == 0);
        step("R4");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule